// File: doc/BRIEF.md
# Inbound Memory Request Decoder

This block sits where requests arriving from the I/O hub enter the memory side of the chip. Each request carries a command (memory read, memory write or I/O), a starting byte address, a byte count from 1 to 256 and a flag that says whether a write wants a completion. The block cuts the request into naturally aligned blocks of `BLK_BYTES` bytes (32 or 64). It issues one output beat per block. Each beat carries a target, an address, a per-byte enable mask trimmed to the bytes the request covers, a snoop flag, a force-all-ones flag for read data, and an optional completion code.

Each block is classified by its first byte against fixed windows: DRAM below the top of memory, the shadow range (treated as DRAM), the SMM window (never accepted), the VGA window (writes only, and only in native graphics mode), and everything at or above 4 GB. The class of the request's first byte decides whether any block can be trusted. Untrusted blocks are not dropped. They are redirected to address zero with no bytes enabled, still snooped and sent to DRAM, and they complete with a master abort.

A new request is taken only when the previous one has issued its last beat.

Top module: `inbound_mem_decoder`

## Requirements
- R1: A request is split into naturally aligned blocks of `BLK_BYTES` bytes. Beats are issued in ascending address order, one per block that the byte range touches. A normally dispatched beat carries the block's aligned base address.
- R2: On a normally dispatched beat, bit i of `out_be_o` is 1 exactly when byte base+i lies within [start, start+len).
- R3: `req_ready_o` is low from the cycle after a request is taken until the last beat has been accepted. While `out_valid_o` is high and `out_ready_i` is low, the beat's address and enables hold steady.
- R4: When the first byte is valid, every block whose class matches the first byte's class is dispatched normally. The target code is 1 for DRAM and 2 for VGA. The snoop flag is 1 for DRAM and 0 for VGA. Any completion carries code 2'b00.
- R5: When the first byte is valid, a block of another class is remapped: address 0, all enables 0, target 1, snoop 1, completion code 2'b01.
- R6: When the first byte is invalid, every block of the request is remapped as in R5.
- R7: Every read beat carries a completion (`out_cpl_vld_o`=1). A remapped read beat raises `out_ones_o` and completes with code 2'b01.
- R8: A write beat carries a completion only when the request's completion flag is set. Otherwise `out_cpl_vld_o` is 0.
- R9: A read block at or above 4 GB is remapped with master abort. A write block at or above 4 GB produces no beat at all.
- R10: A VGA-window block is valid only for a write while `vga_native_i` is 1. SMM-window blocks are never valid. Shadow-range blocks belong to DRAM.
- R11: An I/O command (`req_cmd_i`=2'b10) yields exactly one beat with target 0, address 0, enables 0, snoop 0 and completion code 2'b01.
- R12: After reset, `out_valid_o` is 0 and `req_ready_o` is 1.

Command codes are 2'b00 memory read, 2'b01 memory write and 2'b10 I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vga_native_i | input | 1 | Native graphics mode enable for VGA-window writes |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Decoder idle and able to take a request |
| req_cmd_i | input | 2 | Command code |
| req_addr_i | input | ADDR_W | First byte address |
| req_len_i | input | 9 | Byte count, 1 to 256 |
| req_cpl_i | input | 1 | Write wants a completion |
| out_valid_o | output | 1 | Beat present |
| out_ready_i | input | 1 | Downstream takes the beat |
| out_addr_o | output | ADDR_W | Block address, or 0 when remapped |
| out_be_o | output | BLK_BYTES | Per-byte enables |
| out_tgt_o | output | 2 | 0 none, 1 DRAM, 2 VGA |
| out_snoop_o | output | 1 | Snoop the host bus |
| out_ones_o | output | 1 | Return all-ones read data |
| out_cpl_vld_o | output | 1 | Beat carries a completion |
| out_cpl_code_o | output | 2 | 2'b00 success, 2'b01 master abort |

## Verification
The hardest case to reach is a request whose first byte is valid while a later block falls into a different class. The request must start a few bytes before a window edge and run past it. The table places requests across the DRAM-to-SMM edge, the VGA-to-shadow edge and the shadow-to-DRAM edge. The bench counts successful and aborted completions and compares the enables of the first and last beats. A separate directed case holds `out_ready_i` low for several cycles to show that the beat and the busy state stay frozen.

// File: rtl/inbound_mem_decoder_pkg.sv
package inbound_mem_decoder_pkg;
    typedef enum logic [1:0] {
        CMD_RD = 2'b00,
        CMD_WR = 2'b01,
        CMD_IO = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        CLS_DRAM = 2'b00,
        CLS_VGA  = 2'b01,
        CLS_BAD  = 2'b10,
        CLS_HIGH = 2'b11
    } blk_cls_e;

    localparam logic [1:0] TGT_NONE = 2'd0;
    localparam logic [1:0] TGT_DRAM = 2'd1;
    localparam logic [1:0] TGT_VGA  = 2'd2;

    localparam logic [1:0] CPL_OK    = 2'b00;
    localparam logic [1:0] CPL_ABORT = 2'b01;
endpackage

// File: rtl/imd_window_classify.sv
module imd_window_classify
    import inbound_mem_decoder_pkg::*;
#(
    parameter int              ADDR_W    = 36,
    parameter logic [ADDR_W-1:0] MEM_TOP   = 'h400_0000,
    parameter logic [ADDR_W-1:0] SMM_LO    = 'h3F0_0000,
    parameter logic [ADDR_W-1:0] SMM_HI    = 'h400_0000,
    parameter logic [ADDR_W-1:0] VGA_LO    = 'h00A_0000,
    parameter logic [ADDR_W-1:0] VGA_HI    = 'h00C_0000,
    parameter logic [ADDR_W-1:0] SHADOW_LO = 'h00C_0000,
    parameter logic [ADDR_W-1:0] SHADOW_HI = 'h010_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              is_wr_i,
    input  logic              vga_en_i,
    output blk_cls_e          cls_o
);
    localparam logic [ADDR_W:0] HIGH_BASE = {{(ADDR_W-32){1'b0}}, 1'b1, 32'h0};

    always_comb begin
        if ({1'b0, addr_i} >= HIGH_BASE) begin
            cls_o = CLS_HIGH;
        end else if (addr_i >= SMM_LO && addr_i < SMM_HI) begin
            cls_o = CLS_BAD;
        end else if (addr_i >= VGA_LO && addr_i < VGA_HI) begin
            cls_o = (is_wr_i && vga_en_i) ? CLS_VGA : CLS_BAD;
        end else if (addr_i >= SHADOW_LO && addr_i < SHADOW_HI) begin
            cls_o = CLS_DRAM;
        end else if (addr_i < MEM_TOP) begin
            cls_o = CLS_DRAM;
        end else begin
            cls_o = CLS_BAD;
        end
    end
endmodule

// File: rtl/imd_byte_mask.sv
module imd_byte_mask #(
    parameter int ADDR_W    = 36,
    parameter int BLK_BYTES = 64
) (
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [ADDR_W-1:0]    start_i,
    input  logic [ADDR_W:0]      stop_i,
    output logic [BLK_BYTES-1:0] be_o
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    logic [ADDR_W:0] span;
    logic [OFF_W:0]  hi_cnt;
    logic [OFF_W:0]  lo_off;

    always_comb begin
        span   = stop_i - {1'b0, base_i};
        hi_cnt = (span >= (ADDR_W+1)'(BLK_BYTES)) ? (OFF_W+1)'(BLK_BYTES) : span[OFF_W:0];
        lo_off = (start_i > base_i) ? {1'b0, start_i[OFF_W-1:0]} : '0;
    end

    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
        assign be_o[i] = ((OFF_W+1)'(i) >= lo_off) && ((OFF_W+1)'(i) < hi_cnt);
    end
endmodule

// File: rtl/inbound_mem_decoder.sv
module inbound_mem_decoder
    import inbound_mem_decoder_pkg::*;
#(
    parameter int ADDR_W    = 36,
    parameter int BLK_BYTES = 64,
    parameter int LEN_W     = 9,
    parameter logic [ADDR_W-1:0] MEM_TOP   = 'h400_0000,
    parameter logic [ADDR_W-1:0] SMM_LO    = 'h3F0_0000,
    parameter logic [ADDR_W-1:0] SMM_HI    = 'h400_0000,
    parameter logic [ADDR_W-1:0] VGA_LO    = 'h00A_0000,
    parameter logic [ADDR_W-1:0] VGA_HI    = 'h00C_0000,
    parameter logic [ADDR_W-1:0] SHADOW_LO = 'h00C_0000,
    parameter logic [ADDR_W-1:0] SHADOW_HI = 'h010_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vga_native_i,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic [1:0]           req_cmd_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [LEN_W-1:0]     req_len_i,
    input  logic                 req_cpl_i,
    output logic                 out_valid_o,
    input  logic                 out_ready_i,
    output logic [ADDR_W-1:0]    out_addr_o,
    output logic [BLK_BYTES-1:0] out_be_o,
    output logic [1:0]           out_tgt_o,
    output logic                 out_snoop_o,
    output logic                 out_ones_o,
    output logic                 out_cpl_vld_o,
    output logic [1:0]           out_cpl_code_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLK_BYTES - 1);
    localparam logic [ADDR_W:0]   BLK_STEP   = (ADDR_W+1)'(BLK_BYTES);

    typedef struct packed {
        logic              busy;
        logic [1:0]        cmd;
        logic              cpl;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W:0]   stop;
        logic [ADDR_W-1:0] base;
        blk_cls_e          scls;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0]    first_byte;
    logic [ADDR_W:0]      next_base;
    logic [BLK_BYTES-1:0] blk_be;
    blk_cls_e             cur_cls, req_cls;
    logic                 is_rd, is_io, skip, trusted, last_blk;

    imd_window_classify #(
        .ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP), .SMM_LO(SMM_LO), .SMM_HI(SMM_HI),
        .VGA_LO(VGA_LO), .VGA_HI(VGA_HI), .SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI)
    ) u_cls_req (
        .addr_i  (req_addr_i),
        .is_wr_i (req_cmd_i == CMD_WR),
        .vga_en_i(vga_native_i),
        .cls_o   (req_cls)
    );

    imd_window_classify #(
        .ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP), .SMM_LO(SMM_LO), .SMM_HI(SMM_HI),
        .VGA_LO(VGA_LO), .VGA_HI(VGA_HI), .SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI)
    ) u_cls_blk (
        .addr_i  (first_byte),
        .is_wr_i (st_q.cmd == CMD_WR),
        .vga_en_i(vga_native_i),
        .cls_o   (cur_cls)
    );

    imd_byte_mask #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_mask (
        .base_i (st_q.base),
        .start_i(st_q.start),
        .stop_i (st_q.stop),
        .be_o   (blk_be)
    );

    always_comb begin
        st_d       = st_q;
        first_byte = (st_q.start > st_q.base) ? st_q.start : st_q.base;
        is_rd      = (st_q.cmd == CMD_RD);
        is_io      = (st_q.cmd == CMD_IO);
        skip       = st_q.busy && (st_q.cmd == CMD_WR) && (cur_cls == CLS_HIGH);
        trusted    = (st_q.scls == CLS_DRAM || st_q.scls == CLS_VGA) && (cur_cls == st_q.scls);
        next_base  = {1'b0, st_q.base} + BLK_STEP;
        last_blk   = is_io || (next_base >= st_q.stop);

        req_ready_o = !st_q.busy;
        out_valid_o = st_q.busy && !skip;

        if (is_io) begin
            out_tgt_o      = TGT_NONE;
            out_addr_o     = '0;
            out_be_o       = '0;
            out_snoop_o    = 1'b0;
            out_ones_o     = 1'b0;
            out_cpl_vld_o  = 1'b1;
            out_cpl_code_o = CPL_ABORT;
        end else if (trusted) begin
            out_tgt_o      = (cur_cls == CLS_VGA) ? TGT_VGA : TGT_DRAM;
            out_addr_o     = st_q.base;
            out_be_o       = blk_be;
            out_snoop_o    = (cur_cls == CLS_DRAM);
            out_ones_o     = 1'b0;
            out_cpl_vld_o  = is_rd || st_q.cpl;
            out_cpl_code_o = CPL_OK;
        end else begin
            out_tgt_o      = TGT_DRAM;
            out_addr_o     = '0;
            out_be_o       = '0;
            out_snoop_o    = 1'b1;
            out_ones_o     = is_rd;
            out_cpl_vld_o  = is_rd || st_q.cpl;
            out_cpl_code_o = CPL_ABORT;
        end

        if (!st_q.busy) begin
            if (req_valid_i) begin
                st_d.busy  = 1'b1;
                st_d.cmd   = req_cmd_i;
                st_d.cpl   = req_cpl_i;
                st_d.start = req_addr_i;
                st_d.stop  = {1'b0, req_addr_i} + (ADDR_W+1)'(req_len_i);
                st_d.base  = req_addr_i & ALIGN_MASK;
                st_d.scls  = req_cls;
            end
        end else if (skip || out_ready_i) begin
            if (last_blk) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.base = next_base[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cmd: CMD_RD, cpl: 1'b0, start: '0, stop: '0,
                      base: '0, scls: CLS_BAD};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/inbound_mem_decoder_chk.sv
module inbound_mem_decoder_chk
    import inbound_mem_decoder_pkg::*;
#(
    parameter int ADDR_W    = 36,
    parameter int BLK_BYTES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 vga_native_i,
    input logic                 req_valid_i,
    input logic                 req_ready_o,
    input logic                 out_valid_o,
    input logic                 out_ready_i,
    input logic [ADDR_W-1:0]    out_addr_o,
    input logic [BLK_BYTES-1:0] out_be_o,
    input logic [1:0]           out_tgt_o,
    input logic                 out_snoop_o,
    input logic                 out_ones_o,
    input logic                 out_cpl_vld_o,
    input logic [1:0]           out_cpl_code_o
);
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> !req_ready_o); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o) && $stable(out_be_o)); // R3

    AST_NO_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !out_valid_o); // R3

    AST_DRAM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_tgt_o == TGT_DRAM |-> out_snoop_o); // R4

    AST_ABORT_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_cpl_vld_o && out_cpl_code_o == CPL_ABORT
        |-> out_addr_o == '0 && out_be_o == '0); // R5

    AST_ONES_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ones_o |-> out_cpl_vld_o && out_cpl_code_o == CPL_ABORT); // R7

    AST_VGA_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_tgt_o == TGT_VGA |-> vga_native_i && !out_snoop_o); // R10

    AST_IO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_tgt_o == TGT_NONE
        |-> !out_snoop_o && out_cpl_vld_o && out_cpl_code_o == CPL_ABORT); // R11
endmodule

bind inbound_mem_decoder inbound_mem_decoder_chk #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vga_native_i(vga_native_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_addr_o(out_addr_o), .out_be_o(out_be_o), .out_tgt_o(out_tgt_o),
    .out_snoop_o(out_snoop_o), .out_ones_o(out_ones_o),
    .out_cpl_vld_o(out_cpl_vld_o), .out_cpl_code_o(out_cpl_code_o)
);

// File: tb/inbound_mem_decoder_test.sv
`timescale 1ns/1ps
module inbound_mem_decoder_test;
    localparam int AW = 36;
    localparam int BB = 64;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [1:0]  cmd;
        logic [35:0] addr;
        logic [8:0]  len;
        logic        cpl;
        logic        vga;
        logic [3:0]  kind;
        logic [3:0]  nb;
        logic [3:0]  nok;
        logic [3:0]  nab;
        logic [35:0] faddr;
        logic [63:0] fbe;
        logic [63:0] lbe;
    } vec_t;

    // cmd: 0 read, 1 write, 2 I/O; kind selects the requirement tag in messages
    localparam vec_t VECS [14] = '{
        '{2'd0, 36'h1000,      9'd64,  1'b0, 1'b0, 4'd0, 4'd1, 4'd1, 4'd0, 36'h1000,    ONES, ONES},
        '{2'd0, 36'h1010,      9'd100, 1'b0, 1'b0, 4'd0, 4'd2, 4'd2, 4'd0, 36'h1000,
          64'hFFFF_FFFF_FFFF_0000, 64'h000F_FFFF_FFFF_FFFF},
        '{2'd1, 36'h2000,      9'd256, 1'b0, 1'b0, 4'd6, 4'd4, 4'd0, 4'd0, 36'h2000,    ONES, ONES},
        '{2'd1, 36'h3F0_0000,  9'd32,  1'b1, 1'b0, 4'd2, 4'd1, 4'd0, 4'd1, 36'h0,       64'h0, 64'h0},
        '{2'd0, 36'h3EF_FFC0,  9'd128, 1'b0, 1'b0, 4'd1, 4'd2, 4'd1, 4'd1, 36'h3EF_FFC0, ONES, 64'h0},
        '{2'd2, 36'h60,        9'd4,   1'b0, 1'b0, 4'd3, 4'd1, 4'd0, 4'd1, 36'h0,       64'h0, 64'h0},
        '{2'd0, 36'h1_0000_0000, 9'd16, 1'b0, 1'b0, 4'd4, 4'd1, 4'd0, 4'd1, 36'h0,      64'h0, 64'h0},
        '{2'd1, 36'h1_0000_0000, 9'd64, 1'b1, 1'b0, 4'd4, 4'd0, 4'd0, 4'd0, 36'h0,      64'h0, 64'h0},
        '{2'd1, 36'hA_0000,    9'd64,  1'b1, 1'b1, 4'd5, 4'd1, 4'd1, 4'd0, 36'hA_0000,  ONES, ONES},
        '{2'd1, 36'hA_0000,    9'd64,  1'b1, 1'b0, 4'd5, 4'd1, 4'd0, 4'd1, 36'h0,      64'h0, 64'h0},
        '{2'd0, 36'hA_0000,    9'd64,  1'b0, 1'b1, 4'd5, 4'd1, 4'd0, 4'd1, 36'h0,      64'h0, 64'h0},
        '{2'd1, 36'hB_FFC0,    9'd128, 1'b1, 1'b1, 4'd1, 4'd2, 4'd1, 4'd1, 36'hB_FFC0,  ONES, 64'h0},
        '{2'd0, 36'hF_FFC0,    9'd128, 1'b0, 1'b0, 4'd5, 4'd2, 4'd2, 4'd0, 36'hF_FFC0,  ONES, ONES},
        '{2'd1, 36'h3020,      9'd256, 1'b1, 1'b0, 4'd0, 4'd5, 4'd5, 4'd0, 36'h3000,
          64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vga_native_i = 1'b0;
    logic          req_valid_i = 1'b0;
    logic          req_ready_o;
    logic [1:0]    req_cmd_i = 2'd0;
    logic [AW-1:0] req_addr_i = '0;
    logic [8:0]    req_len_i = 9'd1;
    logic          req_cpl_i = 1'b0;
    logic          out_valid_o;
    logic          out_ready_i = 1'b1;
    logic [AW-1:0] out_addr_o;
    logic [BB-1:0] out_be_o;
    logic [1:0]    out_tgt_o;
    logic          out_snoop_o, out_ones_o, out_cpl_vld_o;
    logic [1:0]    out_cpl_code_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int            n_beats, n_ok, n_ab;
    logic [AW-1:0] f_addr;
    logic [BB-1:0] f_be, l_be;
    logic [1:0]    f_tgt;
    logic          f_snoop, f_ones, f_cplv;

    always #2.5 clk = ~clk;

    inbound_mem_decoder uut (
        .clk(clk), .rst_n(rst_n), .vga_native_i(vga_native_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_len_i(req_len_i),
        .req_cpl_i(req_cpl_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_addr_o(out_addr_o), .out_be_o(out_be_o), .out_tgt_o(out_tgt_o),
        .out_snoop_o(out_snoop_o), .out_ones_o(out_ones_o),
        .out_cpl_vld_o(out_cpl_vld_o), .out_cpl_code_o(out_cpl_code_o)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] cmd, input logic [AW-1:0] addr,
                           input logic [8:0] len, input logic cpl, input logic vga);
        @(negedge clk);
        vga_native_i = vga; req_cmd_i = cmd; req_addr_i = addr;
        req_len_i = len; req_cpl_i = cpl; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        n_beats = 0; n_ok = 0; n_ab = 0;
        f_addr = '0; f_be = '0; l_be = '0; f_tgt = '0;
        f_snoop = 1'b0; f_ones = 1'b0; f_cplv = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (out_valid_o) begin
                if (n_beats == 0) begin
                    f_addr = out_addr_o; f_be = out_be_o; f_tgt = out_tgt_o;
                    f_snoop = out_snoop_o; f_ones = out_ones_o; f_cplv = out_cpl_vld_o;
                end
                l_be = out_be_o;
                if (out_cpl_vld_o && out_cpl_code_o == 2'b00) n_ok++;
                if (out_cpl_vld_o && out_cpl_code_o == 2'b01) n_ab++;
                n_beats++;
            end
            if (!out_valid_o && req_ready_o) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tag;
        #12;
        chk(out_valid_o == 1'b0, "R12 valid in reset", 64'(out_valid_o), 64'd0);
        chk(req_ready_o == 1'b1, "R12 ready in reset", 64'(req_ready_o), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid_o == 1'b0 && req_ready_o == 1'b1, "R12 idle after reset",
            {62'd0, out_valid_o, req_ready_o}, 64'd1);

        for (int v = 0; v < 14; v++) begin
            case (VECS[v].kind)
                4'd0: tag = "R1 R2 R4 normal";
                4'd1: tag = "R5 device crossing";
                4'd2: tag = "R6 invalid start";
                4'd3: tag = "R11 io";
                4'd4: tag = "R9 above 4G";
                4'd5: tag = "R10 window";
                default: tag = "R8 write no completion";
            endcase
            run_req(VECS[v].cmd, VECS[v].addr, VECS[v].len, VECS[v].cpl, VECS[v].vga);
            chk(n_beats == int'(VECS[v].nb), $sformatf("%s beats v%0d", tag, v), 64'(n_beats), 64'(VECS[v].nb));
            chk(n_ok == int'(VECS[v].nok), $sformatf("%s ok v%0d", tag, v), 64'(n_ok), 64'(VECS[v].nok));
            chk(n_ab == int'(VECS[v].nab), $sformatf("%s abort v%0d", tag, v), 64'(n_ab), 64'(VECS[v].nab));
            if (VECS[v].nb != 0) begin
                chk(f_addr == VECS[v].faddr, $sformatf("%s R1 first addr v%0d", tag, v), 64'(f_addr), 64'(VECS[v].faddr));
                chk(f_be == VECS[v].fbe, $sformatf("%s R2 first be v%0d", tag, v), f_be, VECS[v].fbe);
                chk(l_be == VECS[v].lbe, $sformatf("%s R2 last be v%0d", tag, v), l_be, VECS[v].lbe);
            end
        end

        // R6 R7: invalid start read is remapped, snooped, all ones
        run_req(2'd0, 36'h3F0_0040, 9'd64, 1'b0, 1'b0);
        chk(f_tgt == 2'd1 && f_snoop, "R6 remap dram snoop", {62'd0, f_tgt} ^ 64'(f_snoop), 64'd0);
        chk(f_ones && f_cplv, "R7 read ones with completion", {62'd0, f_ones, f_cplv}, 64'd3);

        // R11: io beat has no target and no snoop
        run_req(2'd2, 36'h80, 9'd1, 1'b1, 1'b0);
        chk(f_tgt == 2'd0 && !f_snoop && !f_ones, "R11 io fields", {61'd0, f_tgt, f_snoop}, 64'd0);

        // R10 R4: native VGA write goes to VGA without snoop
        run_req(2'd1, 36'hB_0000, 9'd8, 1'b1, 1'b1);
        chk(f_tgt == 2'd2 && !f_snoop, "R10 vga target", {61'd0, f_tgt, f_snoop}, 64'd4);
        chk(f_be == 64'h0000_0000_0000_00FF, "R4 vga be", f_be, 64'hFF);

        // R8: write without completion flag carries no completion
        run_req(2'd1, 36'h4000, 9'd16, 1'b0, 1'b0);
        chk(!f_cplv && f_tgt == 2'd1 && f_snoop, "R8 no completion beat", {62'd0, f_cplv, f_snoop}, 64'd1);

        // R3: stalled output holds and decoder stays busy
        out_ready_i = 1'b0;
        @(negedge clk);
        req_cmd_i = 2'd0; req_addr_i = 36'h5000; req_len_i = 9'd128; req_cpl_i = 1'b0;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(out_valid_o && out_addr_o == 36'h5000, "R3 first beat", 64'(out_addr_o), 64'h5000);
        repeat (3) @(negedge clk);
        chk(out_valid_o && out_addr_o == 36'h5000 && !req_ready_o, "R3 held under stall", 64'(out_addr_o), 64'h5000);
        out_ready_i = 1'b1;
        @(negedge clk);
        chk(out_valid_o && out_addr_o == 36'h5040 && !req_ready_o, "R3 R1 second block", 64'(out_addr_o), 64'h5040);
        @(negedge clk);
        chk(!out_valid_o && req_ready_o, "R3 idle after last", {62'd0, out_valid_o, req_ready_o}, 64'd1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule